// File: doc/BRIEF.md
# Interrupt Poll and Entry Sequencer

This block is the interrupt-recognition front end of a small pipelined 8-bit processor core. The core tells it which cycle is the final cycle of the current instruction. The block tells the core whether the fetch that follows becomes an interrupt entry instead of a normal opcode. Requests are judged at the start of that final cycle, one cycle ahead of the end of the instruction, because the bus runs one cycle ahead of the work it carries. A request that only shows up during the final cycle waits one more whole instruction. The one exception is the interrupt-disable flag. The core reports it as it will be after any write in the final cycle, and that value still decides whether a level request is taken.

The maskable request is a level input. It re-enters every time the line is low and the disable flag is clear. The non-maskable request is latched on a falling edge and served once. It fires again only after the line goes high and then low again, which is what happens when software re-arms the source while its status is still set. Once an entry is chosen, the block runs a fixed seven-cycle micro-sequence. It starts with a real opcode read at the current program counter, with the counter increment held off. Reset forces the same sequence towards the reset vector, with the pushes turned into reads.

Top module: `intr_front`

## Requirements
- R1: While `rst_n` is low, `ent_step` is 1 and `ent_kind` is 2 (reset), `nmi_pending` is 0 and `take_next` is 0. After release, the sequence runs steps 1 to 7, one per cycle, with no bus writes, and reads the vector at 16'hFFFC then 16'hFFFD.
- R2: An IRQ line that is already low at the clock edge starting an instruction's last cycle, with `dis_next` low in that cycle, raises `take_next` in that cycle. `ent_step` is 1 in the next cycle.
- R3: If the IRQ line first goes low during the last cycle, `take_next` stays 0 in that cycle. The request is taken in the last cycle of the following instruction.
- R4: The IRQ decision uses `dis_next`, the disable flag including any update in the last cycle. When `dis_next` is 1, no IRQ is taken. When it is cleared in the last cycle, the IRQ is taken in that same cycle.
- R5: With the IRQ line held low and the flag clear after an entry, the next instruction's last cycle takes the IRQ again.
- R6: A high-to-low NMI transition sets `nmi_pending` and is taken at a last cycle whatever the value of `dis_next`. A line held low does not trigger again, and a fresh high-then-low transition triggers a second entry.
- R7: When an NMI is pending and IRQ is also active, the entry is an NMI (`ent_kind` 1). The IRQ (`ent_kind` 0) is taken at the next last cycle.
- R8: `nmi_pending` is 0 from the first vector cycle (step 6) of an NMI entry onward.
- R9: The step order is 1 and 2 (opcode-address reads with `pc_hold` high), then 3, 4 and 5 (writes, `push_sel` = 1 for PC high, 2 for PC low, 3 for status with the break bit clear), then 6 and 7 (vector low and high reads). The vector base is 16'hFFFA for NMI, 16'hFFFC for reset and 16'hFFFE for IRQ. Step 0 is idle, with every control low and `vec_addr` at 0.
- R10: `set_dis` is high only in step 6.
- R11: `last_cyc` is ignored during an entry. `take_next` stays 0 and the steps advance unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| last_cyc | input | 1 | Core strobe: the current cycle is the instruction's last |
| dis_next | input | 1 | Interrupt-disable flag including any last-cycle update |
| take_next | output | 1 | The next fetch becomes an interrupt entry |
| ent_step | output | 3 | Entry step, 0 idle, 1 to 7 active |
| ent_kind | output | 2 | Entry kind: 0 IRQ, 1 NMI, 2 reset |
| bus_rd | output | 1 | Entry cycle performs a bus read |
| bus_wr | output | 1 | Entry cycle performs a stack write |
| pc_hold | output | 1 | Suppress program-counter increment |
| push_sel | output | 2 | Push source: 1 PC high, 2 PC low, 3 status |
| vec_addr | output | 16 | Vector byte address during steps 6 and 7 |
| set_dis | output | 1 | Set the interrupt-disable flag |
| nmi_pending | output | 1 | NMI edge latched and not yet served |

## Verification
A wrong sampling register shows up at once as `take_next` rising one instruction too early or too late, in the very cycle where the last-cycle strobe is high. A stuck or mis-cleared NMI latch appears on `nmi_pending` in the first vector cycle, or as an extra entry at the next last cycle. A corrupted step register breaks the bus read and write pattern or the vector address within one cycle of the fault.

// File: rtl/intr_pkg.sv
package intr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DUM1 = 3'd1,
    ST_DUM2 = 3'd2,
    ST_PCH  = 3'd3,
    ST_PCL  = 3'd4,
    ST_PSR  = 3'd5,
    ST_VLO  = 3'd6,
    ST_VHI  = 3'd7
  } ent_step_e;

  typedef enum logic [1:0] {
    K_IRQ = 2'd0,
    K_NMI = 2'd1,
    K_RST = 2'd2
  } ent_kind_e;

  // byte offset of each vector pair above the lowest vector address
  function automatic logic [2:0] vec_offset(ent_kind_e k);
    case (k)
      K_NMI:   return 3'd0;
      K_RST:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/intr_lines.sv
// Input sampling: IRQ level register chain and NMI falling-edge latch.
module intr_lines #(
  parameter int LINE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic nmi_clr,
  output logic irq_act,
  output logic nmi_pend
);
  localparam int LAST = LINE_STAGES;

  logic [LAST:0] irq_c;
  logic [LAST:0] nmi_c;
  logic          nmi_edge;
  logic          pend_d;
  logic          pend_q;

  assign irq_c[0] = irq_n;
  assign nmi_c[0] = nmi_n;

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_c[i] <= 1'b1;
        nmi_c[i] <= 1'b1;
      end else begin
        irq_c[i] <= irq_c[i-1];
        nmi_c[i] <= nmi_c[i-1];
      end
    end
  end

  assign irq_act  = ~irq_c[LAST];
  assign nmi_edge = nmi_c[LAST] & ~nmi_c[LAST-1];

  always_comb begin
    pend_d = pend_q;
    if (nmi_clr) pend_d = 1'b0;
    if (nmi_edge) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign nmi_pend = pend_q;

  // R8: a clear request without a coincident edge empties the latch
  a_r8_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_clr && !nmi_edge) |=> !nmi_pend);

  // R6: latch only rises on an observed falling edge
  a_r6_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && !nmi_edge) |=> !nmi_pend);

endmodule

// File: rtl/intr_poll.sv
// Decision taken in the instruction's last cycle from pre-sampled requests.
module intr_poll
  import intr_pkg::*;
(
  input  logic      idle,
  input  logic      last_cyc,
  input  logic      dis_next,
  input  logic      irq_act,
  input  logic      nmi_pend,
  output logic      take,
  output ent_kind_e kind_sel
);
  logic irq_ok;

  always_comb begin
    irq_ok   = irq_act & ~dis_next;
    take     = idle & last_cyc & (nmi_pend | irq_ok);
    kind_sel = nmi_pend ? K_NMI : K_IRQ;
  end

endmodule

// File: rtl/intr_entry_seq.sv
// Seven-step entry micro-sequence and its bus controls.
module intr_entry_seq
  import intr_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  ent_kind_e         kind_sel,
  output ent_step_e         step,
  output ent_kind_e         kind,
  output logic              idle,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              pc_hold,
  output logic [1:0]        push_sel,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_dis,
  output logic              nmi_clr
);
  ent_step_e state_d, state_q;
  ent_kind_e kind_d, kind_q;
  logic      kind_en;
  logic      in_push, in_vec, is_rst;

  always_comb begin
    state_d = state_q;
    kind_en = 1'b0;
    case (state_q)
      ST_IDLE: if (take) begin
        state_d = ST_DUM1;
        kind_en = 1'b1;
      end
      ST_VHI:  state_d = ST_IDLE;
      default: state_d = ent_step_e'(state_q + 3'd1);
    endcase
    kind_d = kind_en ? kind_sel : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DUM1;
      kind_q  <= K_RST;
    end else begin
      state_q <= state_d;
      if (kind_en) kind_q <= kind_d;
    end
  end

  always_comb begin
    in_push  = (state_q == ST_PCH) || (state_q == ST_PCL) || (state_q == ST_PSR);
    in_vec   = (state_q == ST_VLO) || (state_q == ST_VHI);
    is_rst   = (kind_q == K_RST);
    pc_hold  = (state_q == ST_DUM1) || (state_q == ST_DUM2);
    bus_rd   = pc_hold || in_vec || (in_push && is_rst);
    bus_wr   = in_push && !is_rst;
    case (state_q)
      ST_PCH:  push_sel = 2'd1;
      ST_PCL:  push_sel = 2'd2;
      ST_PSR:  push_sel = 2'd3;
      default: push_sel = 2'd0;
    endcase
    vec_addr = '0;
    if (in_vec)
      vec_addr = VEC_BASE + ADDR_W'(vec_offset(kind_q))
               + ADDR_W'(state_q == ST_VHI);
    set_dis  = (state_q == ST_VLO);
    nmi_clr  = (state_q == ST_PSR) && (kind_q == K_NMI);
  end

  assign step = state_q;
  assign kind = kind_q;
  assign idle = (state_q == ST_IDLE);

  // R9: read and write never overlap
  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));

  // R10: disable flag is set right before the high vector byte
  a_r10_setdis_then_vhi: assert property (@(posedge clk) disable iff (!rst_n)
    set_dis |=> (step == ST_VHI));

endmodule

// File: rtl/intr_front.sv
module intr_front
  import intr_pkg::*;
#(
  parameter int               LINE_STAGES = 1,
  parameter int               ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE    = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              last_cyc,
  input  logic              dis_next,
  output logic              take_next,
  output logic [2:0]        ent_step,
  output logic [1:0]        ent_kind,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              pc_hold,
  output logic [1:0]        push_sel,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_dis,
  output logic              nmi_pending
);
  logic      irq_act, nmi_pend, nmi_clr, idle, take;
  ent_kind_e kind_sel, kind;
  ent_step_e step;

  intr_lines #(.LINE_STAGES(LINE_STAGES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .nmi_n    (nmi_n),
    .nmi_clr  (nmi_clr),
    .irq_act  (irq_act),
    .nmi_pend (nmi_pend)
  );

  intr_poll u_poll (
    .idle     (idle),
    .last_cyc (last_cyc),
    .dis_next (dis_next),
    .irq_act  (irq_act),
    .nmi_pend (nmi_pend),
    .take     (take),
    .kind_sel (kind_sel)
  );

  intr_entry_seq #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .kind_sel (kind_sel),
    .step     (step),
    .kind     (kind),
    .idle     (idle),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .pc_hold  (pc_hold),
    .push_sel (push_sel),
    .vec_addr (vec_addr),
    .set_dis  (set_dis),
    .nmi_clr  (nmi_clr)
  );

  assign take_next   = take;
  assign ent_step    = step;
  assign ent_kind    = kind;
  assign nmi_pending = nmi_pend;

  // R2: a taken decision starts the entry on the next cycle
  a_r2_take_enters: assert property (@(posedge clk) disable iff (!rst_n)
    take_next |=> (ent_step == 3'd1));

  // R11: the poll stays quiet for the whole entry
  a_r11_no_take_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_step != 3'd0) |-> !take_next);

  // R9: active steps advance by one each cycle
  a_r9_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_step != 3'd0 && ent_step != 3'd7) |=> (ent_step == 3'($past(ent_step) + 3'd1)));

  // R9: idle stays idle unless an entry is taken
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_step == 3'd0 && !take_next) |=> (ent_step == 3'd0));

endmodule

// File: tb/tb_intr_front.sv
module tb_intr_front;

  logic        clk = 1'b0;
  logic        rst_n, irq_n, nmi_n, last_cyc, dis_next;
  logic        take_next, bus_rd, bus_wr, pc_hold, set_dis, nmi_pending;
  logic [2:0]  ent_step;
  logic [1:0]  ent_kind, push_sel;
  logic [15:0] vec_addr;

  logic g_irq = 1'b1;
  logic g_nmi = 1'b1;
  int   checks = 0;
  int   fails  = 0;

  always #10 clk = ~clk;

  intr_front dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .last_cyc(last_cyc), .dis_next(dis_next), .take_next(take_next),
    .ent_step(ent_step), .ent_kind(ent_kind), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .pc_hold(pc_hold), .push_sel(push_sel), .vec_addr(vec_addr),
    .set_dis(set_dis), .nmi_pending(nmi_pending)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bench window: drive after the falling edge, settle, then sample
  task automatic tick(input logic last, input logic dis);
    @(negedge clk);
    irq_n    = g_irq;
    nmi_n    = g_nmi;
    last_cyc = last;
    dis_next = dis;
    #1;
  endtask

  function automatic logic [24:0] exp_vec(input int s, input int k);
    logic rd, wr, hold, sd;
    logic [1:0] ps;
    logic [15:0] va;
    logic [15:0] base;
    base = (k == 1) ? 16'hFFFA : (k == 2) ? 16'hFFFC : 16'hFFFE;
    hold = (s == 1 || s == 2);
    rd   = hold || s == 6 || s == 7 || (s >= 3 && s <= 5 && k == 2);
    wr   = (s >= 3 && s <= 5 && k != 2);
    ps   = (s >= 3 && s <= 5) ? 2'(s - 2) : 2'd0;
    sd   = (s == 6);
    va   = (s == 6) ? base : (s == 7) ? base + 16'd1 : 16'd0;
    return {3'(s), rd, wr, hold, ps, sd, va};
  endfunction

  // current window is step 1 on entry to this task
  task automatic check_entry(input int k, input logic lastin, input logic dis,
                             input string req);
    for (int s = 1; s <= 7; s++) begin
      if (s != 1) tick(lastin, dis);
      check(req, $sformatf("step %0d controls", s),
            32'({ent_step, bus_rd, bus_wr, pc_hold, push_sel, set_dis, vec_addr}),
            32'(exp_vec(s, k)));
      if (s == 1) check(req, "entry kind", 32'(ent_kind), 32'(k));
      if (lastin) check("R11", $sformatf("no take in step %0d", s), 32'(take_next), 32'd0);
      if (k == 1 && s >= 6) check("R8", $sformatf("nmi latch clear in step %0d", s),
                                  32'(nmi_pending), 32'd0);
    end
    tick(1'b0, dis);
    check(req, "idle after entry",
          32'({ent_step, bus_rd, bus_wr, pc_hold, push_sel, set_dis, vec_addr}),
          32'(exp_vec(0, k)));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; last_cyc = 1'b0; dis_next = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "step in reset", 32'(ent_step), 32'd1);
    check("R1", "kind in reset", 32'(ent_kind), 32'd2);
    check("R1", "nmi latch in reset", 32'(nmi_pending), 32'd0);
    check("R1", "no take in reset", 32'(take_next), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_entry(2, 1'b0, 1'b1, "R1");
  endtask

  task automatic t_irq_basic;
    g_irq = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    check("R2", "take with line low before last cycle", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(0, 1'b0, 1'b1, "R9");
    g_irq = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  task automatic t_irq_defer;
    g_irq = 1'b0;
    tick(1'b1, 1'b0);
    check("R3", "late IRQ not taken", 32'(take_next), 32'd0);
    tick(1'b0, 1'b0);
    check("R3", "no take mid instruction", 32'(take_next), 32'd0);
    tick(1'b1, 1'b0);
    check("R3", "taken next last cycle", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(0, 1'b0, 1'b1, "R3");
    g_irq = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  task automatic t_irq_mask;
    g_irq = 1'b0;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    check("R4", "masked IRQ", 32'(take_next), 32'd0);
    tick(1'b1, 1'b0);
    check("R4", "flag cleared in last cycle", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(0, 1'b0, 1'b0, "R4");
    // R5: flag left clear, line still low
    tick(1'b1, 1'b0);
    check("R5", "level re-entry", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(0, 1'b0, 1'b1, "R5");
    g_irq = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  task automatic t_nmi_edge;
    g_nmi = 1'b0;
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    check("R6", "edge latched", 32'(nmi_pending), 32'd1);
    tick(1'b1, 1'b1);
    check("R6", "NMI taken with flag set", 32'(take_next), 32'd1);
    tick(1'b0, 1'b1);
    check_entry(1, 1'b0, 1'b1, "R6");
    tick(1'b1, 1'b1);
    check("R6", "held low no retrigger", 32'({take_next, nmi_pending}), 32'd0);
    g_nmi = 1'b1;
    tick(1'b0, 1'b1);
    g_nmi = 1'b0;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    check("R6", "second edge retriggers", 32'(take_next), 32'd1);
    tick(1'b0, 1'b1);
    check_entry(1, 1'b0, 1'b1, "R6");
    g_nmi = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  task automatic t_priority;
    g_irq = 1'b0;
    g_nmi = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    check("R7", "take with both pending", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(1, 1'b0, 1'b0, "R7");
    tick(1'b1, 1'b0);
    check("R7", "IRQ follows NMI", 32'(take_next), 32'd1);
    tick(1'b0, 1'b0);
    check_entry(0, 1'b0, 1'b1, "R7");
    g_irq = 1'b1;
    g_nmi = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  task automatic t_ignore_last;
    g_irq = 1'b0;
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    check("R11", "take before strobed entry", 32'(take_next), 32'd1);
    tick(1'b1, 1'b0);
    check_entry(0, 1'b1, 1'b0, "R11");
    g_irq = 1'b1;
    tick(1'b0, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_basic();
    t_irq_defer();
    t_irq_mask();
    t_nmi_edge();
    t_priority();
    t_ignore_last();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule